// File: doc/BRIEF.md
# Bit-Serial SIMD Mesh Array

A two-dimensional grid of one-bit processing elements that all execute the same control word in every clock cycle. Each element owns a private bit memory, three single-bit operand latches feeding a one-bit adder/subtractor, and a separate transfer latch. Operands move in one-bit steps between mesh neighbours. The grid's outer elements connect to boundary ports on all four sides, so several arrays can be tiled into a larger mesh.

A host sequencer drives one instruction per cycle. The instruction holds a source select for each operand latch, a memory write with its data select, a column shift enable, a memory-to-transfer-latch load, and a memory address shared by every element. Multi-bit arithmetic runs one bit per step, with the carry latch kept between steps. The transfer latches form one shift chain per column, from top to bottom. Data can therefore stream into and out of the array while the operand latches compute.

Top module: `simd_mesh_array`

## Requirements
- R1: An active-low asynchronous reset clears every operand latch and every transfer latch. All edge outputs and `io_o` then read 0. Memory contents stay undefined until written.
- R2: The control word is applied to every element in the same cycle. Its layout is: a-select `instr_i[3:0]`, b-select `[7:4]`, c-select `[11:8]`, write enable `[12]`, write-data select `[14:13]`, column shift `[15]`, memory-to-transfer load `[16]`, address `[16+ADDR_W:17]`. In every select field, codes 6 and 7 load constant 0 and constant 1.
- R3: Select codes 2, 3, 4 and 5 load the a-latch of the neighbour to the north, south, east or west. An element on an edge takes that side's boundary input instead (bit index = column for north/south, row for east/west, row 0 at the top, column 0 at the west). `north_o`, `south_o`, `west_o` and `east_o` show the a-latches of the outer row or column.
- R4: Select code 0, and any code above 10, holds the latch. Boundary inputs then have no effect.
- R5: Select codes 8, 9 and 10 load the ALU's sum, carry and borrow. These are computed from the current a, b and c latches: sum = a xor b xor c, carry is set when a+b+c ≥ 2, and borrow is set when a−b−c < 0.
- R6: Select code 1 loads the addressed memory bit. With write enable set, the addressed bit takes the value chosen by the write-data select: 0 sum, 1 a-latch, 2 transfer latch, 3 carry. With write enable clear, memory is unchanged.
- R7: With the column shift set, each transfer latch takes the value of the one above it, and row 0 takes `io_i`. `io_o` shows the bottom row. The shift runs in the same cycles as any operand-latch activity.
- R8: With the load bit set, each transfer latch takes its addressed memory bit. The load takes priority over a shift in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 17+ADDR_W | Broadcast control word with the shared address |
| north_i | input | COLS | Boundary bits entering the top row |
| south_i | input | COLS | Boundary bits entering the bottom row |
| west_i | input | ROWS | Boundary bits entering the left column |
| east_i | input | ROWS | Boundary bits entering the right column |
| io_i | input | COLS | Serial data entering the top row of the transfer chains |
| north_o | output | COLS | a-latches of the top row |
| south_o | output | COLS | a-latches of the bottom row |
| west_o | output | ROWS | a-latches of the left column |
| east_o | output | ROWS | a-latches of the right column |
| io_o | output | COLS | Transfer latches of the bottom row |

## Verification
The assertions assume that `instr_i` and all boundary and serial inputs are stable across each rising edge. They also assume the array has at least two rows, so that the shift check can compare the bottom row with the row above it. The stimulus changes every input only on the falling edge. It exercises the north, west and shift paths only after the grid has been set to a known constant. Memory is read back only at addresses the stimulus has already written, which keeps every expected value defined.

// File: rtl/simd_mesh_pkg.sv
package simd_mesh_pkg;

  typedef enum logic [3:0] {
    SRC_HOLD   = 4'd0,
    SRC_RAM    = 4'd1,
    SRC_N      = 4'd2,
    SRC_S      = 4'd3,
    SRC_E      = 4'd4,
    SRC_W      = 4'd5,
    SRC_ZERO   = 4'd6,
    SRC_ONE    = 4'd7,
    SRC_SUM    = 4'd8,
    SRC_CARRY  = 4'd9,
    SRC_BORROW = 4'd10
  } src_e;

  typedef enum logic [1:0] {
    WR_SUM   = 2'd0,
    WR_A     = 2'd1,
    WR_IO    = 2'd2,
    WR_CARRY = 2'd3
  } wsel_e;

  // first member is the MSB: a_sel lands on bits [3:0]
  typedef struct packed {
    logic  io_load;
    logic  io_shift;
    wsel_e wsel;
    logic  we;
    src_e  c_sel;
    src_e  b_sel;
    src_e  a_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/simd_alu.sv
module simd_alu (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic carry_o,
  output logic borrow_o
);

  assign sum_o    = a_i ^ b_i ^ c_i;
  assign carry_o  = (a_i & b_i) | (c_i & (a_i ^ b_i));
  assign borrow_o = (~a_i & (b_i | c_i)) | (b_i & c_i);

  always_comb begin
    a_r5_add: assert ({carry_o, sum_o} == 2'(a_i) + 2'(b_i) + 2'(c_i))
      else $error("R5 add mismatch");
    a_r5_sub: assert ({borrow_o, borrow_o, sum_o} == 3'(a_i) - 3'(b_i) - 3'(c_i))
      else $error("R5 subtract mismatch");
  end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_mesh_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              n_i,
  input  logic              s_i,
  input  logic              e_i,
  input  logic              w_i,
  input  logic              io_in_i,
  output logic              a_o,
  output logic              io_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic             a_q, b_q, c_q, io_q;
  logic             a_d, b_d, c_d, io_d;
  logic [DEPTH-1:0] mem_q;
  logic             rd_bit, wr_bit;
  logic             sum, carry, borrow;

  assign rd_bit = mem_q[addr_i];

  simd_alu u_alu (
    .a_i     (a_q),
    .b_i     (b_q),
    .c_i     (c_q),
    .sum_o   (sum),
    .carry_o (carry),
    .borrow_o(borrow)
  );

  function automatic logic pick(input src_e sel, input logic cur, input logic ram,
                                input logic n, input logic s, input logic e,
                                input logic w, input logic sm, input logic cy,
                                input logic bw);
    case (sel)
      SRC_RAM:    pick = ram;
      SRC_N:      pick = n;
      SRC_S:      pick = s;
      SRC_E:      pick = e;
      SRC_W:      pick = w;
      SRC_ZERO:   pick = 1'b0;
      SRC_ONE:    pick = 1'b1;
      SRC_SUM:    pick = sm;
      SRC_CARRY:  pick = cy;
      SRC_BORROW: pick = bw;
      default:    pick = cur;
    endcase
  endfunction

  always_comb begin
    a_d = pick(ctrl_i.a_sel, a_q, rd_bit, n_i, s_i, e_i, w_i, sum, carry, borrow);
    b_d = pick(ctrl_i.b_sel, b_q, rd_bit, n_i, s_i, e_i, w_i, sum, carry, borrow);
    c_d = pick(ctrl_i.c_sel, c_q, rd_bit, n_i, s_i, e_i, w_i, sum, carry, borrow);
  end

  always_comb begin
    case (ctrl_i.wsel)
      WR_SUM:  wr_bit = sum;
      WR_A:    wr_bit = a_q;
      WR_IO:   wr_bit = io_q;
      default: wr_bit = carry;
    endcase
  end

  // memory transfer wins over the column shift
  always_comb begin
    if (ctrl_i.io_load)       io_d = rd_bit;
    else if (ctrl_i.io_shift) io_d = io_in_i;
    else                      io_d = io_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q  <= 1'b0;
      b_q  <= 1'b0;
      c_q  <= 1'b0;
      io_q <= 1'b0;
    end else begin
      a_q  <= a_d;
      b_q  <= b_d;
      c_q  <= c_d;
      io_q <= io_d;
    end
  end

  // bit memory is not reset
  always_ff @(posedge clk_i) begin
    if (ctrl_i.we) mem_q[addr_i] <= wr_bit;
  end

  assign a_o  = a_q;
  assign io_o = io_q;

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.a_sel == SRC_HOLD |=> $stable(a_q))
    else $error("R4 a-latch changed on hold");

  a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.io_load |=> io_q == $past(rd_bit))
    else $error("R8 transfer latch missed memory load");

endmodule

// File: rtl/simd_mesh_array.sv
module simd_mesh_array
  import simd_mesh_pkg::*;
#(
  parameter int ROWS   = 6,
  parameter int COLS   = 12,
  parameter int ADDR_W = 7,
  localparam int INSTR_W = CTRL_W + ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [COLS-1:0]    north_i,
  input  logic [COLS-1:0]    south_i,
  input  logic [ROWS-1:0]    west_i,
  input  logic [ROWS-1:0]    east_i,
  input  logic [COLS-1:0]    io_i,
  output logic [COLS-1:0]    north_o,
  output logic [COLS-1:0]    south_o,
  output logic [ROWS-1:0]    west_o,
  output logic [ROWS-1:0]    east_o,
  output logic [COLS-1:0]    io_o
);

  ctrl_t                       ctrl;
  logic [ADDR_W-1:0]           addr;
  logic [ROWS-1:0][COLS-1:0]   a_grid;
  logic [ROWS-1:0][COLS-1:0]   io_grid;

  assign ctrl = ctrl_t'(instr_i[CTRL_W-1:0]);
  assign addr = instr_i[INSTR_W-1:CTRL_W];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic n_in, s_in, e_in, w_in, io_in;

      if (r == 0) begin : g_n_edge
        assign n_in  = north_i[c];
        assign io_in = io_i[c];
      end else begin : g_n_mesh
        assign n_in  = a_grid[r-1][c];
        assign io_in = io_grid[r-1][c];
      end

      if (r == ROWS-1) begin : g_s_edge
        assign s_in = south_i[c];
      end else begin : g_s_mesh
        assign s_in = a_grid[r+1][c];
      end

      if (c == 0) begin : g_w_edge
        assign w_in = west_i[r];
      end else begin : g_w_mesh
        assign w_in = a_grid[r][c-1];
      end

      if (c == COLS-1) begin : g_e_edge
        assign e_in = east_i[r];
      end else begin : g_e_mesh
        assign e_in = a_grid[r][c+1];
      end

      simd_pe #(.ADDR_W(ADDR_W)) u_pe (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ctrl_i (ctrl),
        .addr_i (addr),
        .n_i    (n_in),
        .s_i    (s_in),
        .e_i    (e_in),
        .w_i    (w_in),
        .io_in_i(io_in),
        .a_o    (a_grid[r][c]),
        .io_o   (io_grid[r][c])
      );
    end

    assign west_o[r] = a_grid[r][0];
    assign east_o[r] = a_grid[r][COLS-1];
  end

  assign north_o = a_grid[0];
  assign south_o = a_grid[ROWS-1];
  assign io_o    = io_grid[ROWS-1];

  a_r3_north_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.a_sel == SRC_N |=> north_o == $past(north_i))
    else $error("R3 north boundary not captured");

  a_r3_west_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.a_sel == SRC_W |=> west_o == $past(west_i))
    else $error("R3 west boundary not captured");

  if (ROWS > 1) begin : g_shift_chk
    a_r7_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl.io_shift && !ctrl.io_load) |=> io_o == $past(io_grid[ROWS-2]))
      else $error("R7 column shift broken");
  end

endmodule

// File: tb/sim_simd_mesh_array.sv
module sim_simd_mesh_array;

  localparam int ROWS    = 6;
  localparam int COLS    = 12;
  localparam int ADDR_W  = 7;
  localparam int INSTR_W = 17 + ADDR_W;

  // {a, b, c, sum, carry, borrow}
  localparam logic [5:0] ALU_VEC [8] = '{
    6'b000_000, 6'b001_101, 6'b010_101, 6'b011_011,
    6'b100_100, 6'b101_010, 6'b110_010, 6'b111_111
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic [INSTR_W-1:0] instr = '0;
  logic [COLS-1:0] north_i = '0, south_i = '0, io_i = '0;
  logic [ROWS-1:0] west_i = '0, east_i = '0;
  logic [COLS-1:0] north_o, south_o, io_o;
  logic [ROWS-1:0] west_o, east_o;

  int checks = 0;
  int errors = 0;
  logic [COLS-1:0] pat [ROWS];

  always #10 clk = ~clk;

  simd_mesh_array #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr),
    .north_i(north_i), .south_i(south_i), .west_i(west_i), .east_i(east_i),
    .io_i(io_i), .north_o(north_o), .south_o(south_o), .west_o(west_o),
    .east_o(east_o), .io_o(io_o)
  );

  function automatic logic [INSTR_W-1:0] mk(input logic [3:0] a, input logic [3:0] b,
                                            input logic [3:0] c, input logic we,
                                            input logic [1:0] ws, input logic sh,
                                            input logic ld, input logic [ADDR_W-1:0] ad);
    return {ad, ld, sh, ws, we, c, b, a};
  endfunction

  task automatic cyc(input logic [INSTR_W-1:0] v);
    @(negedge clk);
    instr = v;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 north_o", 32'(north_o), 32'h0);
    chk("R1 south_o", 32'(south_o), 32'h0);
    chk("R1 west_o", 32'(west_o), 32'h0);
    chk("R1 east_o", 32'(east_o), 32'h0);
    chk("R1 io_o", 32'(io_o), 32'h0);

    // R2 broadcast constants
    cyc(mk(7, 6, 6, 0, 0, 0, 0, 0));
    chk("R2 const one north", 32'(north_o), 32'(12'hFFF));
    chk("R2 const one east", 32'(east_o), 32'(6'h3F));
    cyc(mk(6, 6, 6, 0, 0, 0, 0, 0));
    chk("R2 const zero south", 32'(south_o), 32'h0);

    // R3 north boundary flows down
    north_i = 12'hA5C;
    cyc(mk(2, 0, 0, 0, 0, 0, 0, 0));
    chk("R3 north entry", 32'(north_o), 32'(12'hA5C));
    repeat (4) cyc(mk(2, 0, 0, 0, 0, 0, 0, 0));
    chk("R3 south before arrival", 32'(south_o), 32'h0);
    cyc(mk(2, 0, 0, 0, 0, 0, 0, 0));
    chk("R3 south after arrival", 32'(south_o), 32'(12'hA5C));

    // R4 hold ignores boundary
    north_i = 12'h3F0;
    cyc(mk(0, 0, 0, 0, 0, 0, 0, 0));
    chk("R4 hold north", 32'(north_o), 32'(12'hA5C));

    // R3 west boundary flows east
    cyc(mk(6, 0, 0, 0, 0, 0, 0, 0));
    west_i = 6'b101101;
    repeat (11) cyc(mk(5, 0, 0, 0, 0, 0, 0, 0));
    chk("R3 east before arrival", 32'(east_o), 32'h0);
    cyc(mk(5, 0, 0, 0, 0, 0, 0, 0));
    chk("R3 east after arrival", 32'(east_o), 32'(6'b101101));

    // R7 column shift while a-latches load constant one
    cyc(mk(6, 0, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < ROWS; k++) begin
      pat[k] = 12'(12'h111 * (k + 1));
      io_i = pat[k];
      cyc(mk(7, 0, 0, 0, 0, 1, 0, 0));
      if (k == ROWS - 2) chk("R7 io before arrival", 32'(io_o), 32'h0);
    end
    chk("R7 io first pattern out", 32'(io_o), 32'(pat[0]));
    chk("R7 overlap compute", 32'(north_o), 32'(12'hFFF));

    // R6 transfer latch to memory, read back through a-latch
    cyc(mk(0, 0, 0, 1, 2, 0, 0, 7'd5));
    cyc(mk(1, 0, 0, 0, 0, 0, 0, 7'd5));
    chk("R6 io write top row", 32'(north_o), 32'(pat[ROWS-1]));
    chk("R6 io write bottom row", 32'(south_o), 32'(pat[0]));

    // R8 load from memory beats shift
    io_i = '0;
    cyc(mk(0, 0, 0, 0, 0, 1, 0, 0));
    io_i = 12'hFFF;
    cyc(mk(0, 0, 0, 0, 0, 1, 1, 7'd5));
    chk("R8 load priority", 32'(io_o), 32'(pat[0]));
    io_i = '0;
    repeat (5) cyc(mk(0, 0, 0, 0, 0, 1, 0, 0));
    chk("R8 loaded top row shifted out", 32'(io_o), 32'(pat[ROWS-1]));

    // R6 write disabled leaves memory
    cyc(mk(6, 0, 0, 0, 1, 0, 0, 7'd5));
    cyc(mk(1, 0, 0, 0, 0, 0, 0, 7'd5));
    chk("R6 no write when disabled", 32'(north_o), 32'(pat[ROWS-1]));

    // R6 a-latch write
    cyc(mk(7, 0, 0, 0, 0, 0, 0, 0));
    cyc(mk(0, 0, 0, 1, 1, 0, 0, 7'd9));
    cyc(mk(6, 0, 0, 0, 0, 0, 0, 0));
    cyc(mk(1, 0, 0, 0, 0, 0, 0, 7'd9));
    chk("R6 a write", 32'(north_o), 32'(12'hFFF));

    // R5 ALU vectors
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = ALU_VEC[i];
      cyc(mk(v[5] ? 4'd7 : 4'd6, v[4] ? 4'd7 : 4'd6, v[3] ? 4'd7 : 4'd6, 0, 0, 0, 0, 0));
      cyc(mk(0, 0, 0, 1, 0, 0, 0, 7'd20));
      cyc(mk(0, 0, 0, 1, 3, 0, 0, 7'd21));
      cyc(mk(0, 0, 10, 0, 0, 0, 0, 0));
      cyc(mk(1, 6, 0, 0, 0, 0, 0, 7'd20));
      chk($sformatf("R5 sum abc=%0b", v[5:3]), 32'(north_o), 32'({COLS{v[2]}}));
      cyc(mk(1, 0, 0, 0, 0, 0, 0, 7'd21));
      chk($sformatf("R5 carry abc=%0b", v[5:3]), 32'(north_o), 32'({COLS{v[1]}}));
      cyc(mk(6, 0, 0, 0, 0, 0, 0, 0));
      cyc(mk(0, 0, 0, 1, 0, 0, 0, 7'd22));
      cyc(mk(1, 0, 0, 0, 0, 0, 0, 7'd22));
      chk($sformatf("R5 borrow abc=%0b", v[5:3]), 32'(north_o), 32'({COLS{v[0]}}));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule